// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer with Clock-Crossing Register Writes

The block is a watchdog timer whose down-counter runs on a slow watchdog clock, nominally 32 kHz. Software controls it from a faster bus clock through a small register set: a control word, a reload value, a window threshold, a keyed refresh register and a status word. When the count expires, or when software breaks the refresh rules, the block raises either a sticky reset request or an interrupt. A control bit selects which one.

Every bus write that affects the slow domain is carried across the clock boundary by a toggle handshake through two-flop synchronizers. Each of the four writable registers has its own busy flag in the status word. While that flag is set, a further write to the same register is dropped. Setting the enable bit locks the configuration until the next system reset. A low-power input can pause the countdown. A valid refresh that arrives while the count is still above the window threshold counts as a violation.

Top module: `wd_keyed`

## Requirements
- R1: Writing the key 0xCCCC to address 3 takes effect on the third rising watchdog-clock edge after the bus write edge. At that edge it reloads the count from the reload value and clears a pending interrupt.
- R2: Writing any value other than 0xCCCC to address 3 is a violation. It triggers the same action as a timeout on the edge where the write takes effect.
- R3: Address 3 always reads back as zero.
- R4: Control bit 0 picks the expiry action. With 0, `wd_reset` rises and stays high until `rst_n`. With 1, `wd_irq` rises and the count reloads.
- R5: Counting starts only when the enable bit (control bit 5) is set. Once the enable takes effect, the count steps down from the reload value by one per running watchdog edge. The action fires on the running edge where the count is already zero.
- R6: Control bit 1 set freezes the count while `low_power` is high, and counting resumes from the held value afterwards. With bit 1 clear, counting continues during low power.
- R7: Status bits 1 to 4 are the busy flags for control, reload, window and refresh. Each reads 1 from the bus edge of an accepted write. It returns to 0 after the second bus edge that follows the watchdog edge where the write takes effect.
- R8: A write to a register whose busy flag is set is ignored.
- R9: Status bit 5 (lock) sets on an accepted control write with bit 5 high. Once lock is set, writes to addresses 0 to 2 are ignored. Lock clears only on `rst_n`.
- R10: A 0xCCCC refresh that takes effect while enabled and with the count above the window threshold (address 2) is a violation.
- R11: Status bit 0 mirrors `wd_irq` two bus clocks later.
- R12: After reset, the registers read back as follows: control 0x0002, reload 0x0400, window 0xFFFF, status 0. Both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_wd | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, bus domain |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| low_power | input | 1 | Low-power mode, synchronous to `clk_wd` |
| wd_reset | output | 1 | Sticky reset request |
| wd_irq | output | 1 | Interrupt pending |

## Verification
A wrong count or a wrong decode of the refresh rules shows up at the outputs. `wd_irq` or `wd_reset` moves on a different watchdog edge from the one the model predicts. This is seen within one watchdog period of the fault, or at the latest when the timeout falls due. A fault in the clock-crossing bookkeeping shows up in the status word within a few bus clocks, as a busy flag that clears too early or too late, or as a dropped or extra write. A broken lock shows up at the next read of the configuration.

// File: rtl/wd_keyed.sv
module wd_keyed #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter logic [DW-1:0] KEY = 16'hCCCC,
  parameter logic [DW-1:0] LOAD_RST = 16'h0400,
  parameter logic [DW-1:0] WIN_RST = '1
) (
  input  logic          clk_bus,
  input  logic          clk_wd,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          low_power,
  output logic          wd_reset,
  output logic          wd_irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_LOAD = AW'(1);
  localparam logic [AW-1:0] A_WIN  = AW'(2);
  localparam logic [AW-1:0] A_KICK = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [2:0] CTRL_RST = 3'b010;

  logic [2:0]    ctrl_b, ctrl_s;
  logic [DW-1:0] load_b, win_b, load_s, win_s, cnt;
  logic          key_ok_b, lock_b, irq_q, rst_q;
  logic [3:0]    tg, a1, a2, s1, s2, s3, busy, take, apply;
  logic [1:0]    irq_sy;

  assign busy  = tg ^ a2;
  assign apply = s2 ^ s3;

  assign take[0] = wr_en && addr == A_CTRL && !busy[0] && !lock_b;
  assign take[1] = wr_en && addr == A_LOAD && !busy[1] && !lock_b;
  assign take[2] = wr_en && addr == A_WIN  && !busy[2] && !lock_b;
  assign take[3] = wr_en && addr == A_KICK && !busy[3];

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_b   <= CTRL_RST;
      load_b   <= LOAD_RST;
      win_b    <= WIN_RST;
      key_ok_b <= 1'b0;
      lock_b   <= 1'b0;
      tg       <= '0;
      a1       <= '0;
      a2       <= '0;
      irq_sy   <= '0;
    end else begin
      a1     <= s3;
      a2     <= a1;
      irq_sy <= {irq_sy[0], irq_q};
      tg     <= tg ^ take;
      if (take[0]) begin
        ctrl_b <= {wdata[5], wdata[1], wdata[0]};
        if (wdata[5]) lock_b <= 1'b1;
      end
      if (take[1]) load_b <= wdata;
      if (take[2]) win_b <= wdata;
      if (take[3]) key_ok_b <= (wdata == KEY);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0] = ctrl_b[0];
        rdata[1] = ctrl_b[1];
        rdata[5] = ctrl_b[2];
      end
      A_LOAD: rdata = load_b;
      A_WIN:  rdata = win_b;
      A_STAT: begin
        rdata[0]   = irq_sy[1];
        rdata[4:1] = busy;
        rdata[5]   = lock_b;
      end
      default: rdata = '0;
    endcase
  end

  wire en     = ctrl_s[2];
  wire pds    = ctrl_s[1];
  wire act    = ctrl_s[0];
  wire kick   = apply[3];
  wire early  = en && (cnt > win_s);
  wire viol   = kick && (!key_ok_b || early);
  wire good   = kick && !viol;
  wire run    = en && !(pds && low_power);
  wire expire = run && (cnt == '0) && !kick;
  wire fire   = viol || expire;

  always_ff @(posedge clk_wd or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      ctrl_s <= CTRL_RST;
      load_s <= LOAD_RST;
      win_s  <= WIN_RST;
      cnt    <= LOAD_RST;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      s1 <= tg;
      s2 <= s1;
      s3 <= s2;
      if (apply[0]) ctrl_s <= ctrl_b;
      if (apply[1]) load_s <= load_b;
      if (apply[2]) win_s <= win_b;
      if (!en || good || expire) cnt <= load_s;
      else if (run) cnt <= cnt - 1'b1;
      if (fire && act) irq_q <= 1'b1;
      else if (good) irq_q <= 1'b0;
      if (fire && !act) rst_q <= 1'b1;
    end
  end

  assign wd_reset = rst_q;
  assign wd_irq   = irq_q;
endmodule

// File: rtl/wd_keyed_chk.sv
module wd_keyed_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk_bus,
  input logic          clk_wd,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          lock_b,
  input logic [2:0]    ctrl_b,
  input logic [DW-1:0] load_b,
  input logic [3:0]    busy,
  input logic          wd_reset
);
  a_r9_lock_sticky: assert property (@(posedge clk_bus) disable iff (!rst_n)
    lock_b |=> lock_b);

  a_r9_cfg_frozen: assert property (@(posedge clk_bus) disable iff (!rst_n)
    lock_b |=> ($stable(ctrl_b) && $stable(load_b)));

  a_r8_busy_drops_write: assert property (@(posedge clk_bus) disable iff (!rst_n)
    busy[1] |=> $stable(load_b));

  a_r7_busy_on_write: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && !busy[1] && !lock_b) |=> busy[1]);

  a_r4_reset_sticky: assert property (@(posedge clk_wd) disable iff (!rst_n)
    wd_reset |=> wd_reset);
endmodule

bind wd_keyed wd_keyed_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_bus(clk_bus), .clk_wd(clk_wd), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .lock_b(lock_b), .ctrl_b(ctrl_b), .load_b(load_b), .busy(busy), .wd_reset(wd_reset)
);

// File: tb/wd_keyed_test.sv
module wd_keyed_test;
  localparam logic [15:0] KEY = 16'hCCCC;
  localparam logic [15:0] LOAD0 = 16'h0400;

  logic clk = 0, clk_w = 0, rst_n = 0, we = 0, lowpwr = 0;
  logic [2:0] addr = 3'd4;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic wd_reset, wd_irq;
  int checks = 0, fails = 0;
  bit stop = 0;

  wd_keyed uut (.clk_bus(clk), .clk_wd(clk_w), .rst_n(rst_n), .wr_en(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .low_power(lowpwr), .wd_reset(wd_reset), .wd_irq(wd_irq));

  always #10 clk = ~clk;
  initial begin
    #15;
    forever begin clk_w = 1; #80; clk_w = 0; #80; end
  end

  // behavioural reference model
  logic [15:0] m_ctrl_b, m_load_b, m_win_b, m_ctrl_s, m_load_s, m_win_s, m_cnt;
  bit m_kok, m_lock, m_irq, m_rst, m_i1, m_i2;
  bit [3:0] m_busy;
  int m_sq[4];
  int m_ack[4];

  task automatic m_reset();
    m_ctrl_b = 16'h0002; m_ctrl_s = 16'h0002;
    m_load_b = LOAD0; m_load_s = LOAD0; m_cnt = LOAD0;
    m_win_b = 16'hFFFF; m_win_s = 16'hFFFF;
    m_kok = 0; m_lock = 0; m_irq = 0; m_rst = 0; m_i1 = 0; m_i2 = 0; m_busy = 0;
    for (int i = 0; i < 4; i++) begin m_sq[i] = -1; m_ack[i] = 0; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit [3:0] acc;
      acc = 0;
      if (we) begin
        case (addr)
          3'd0: acc[0] = !m_busy[0] && !m_lock;
          3'd1: acc[1] = !m_busy[1] && !m_lock;
          3'd2: acc[2] = !m_busy[2] && !m_lock;
          3'd3: acc[3] = !m_busy[3];
          default: ;
        endcase
      end
      for (int i = 0; i < 4; i++)
        if (m_ack[i] > 0) begin
          m_ack[i]--;
          if (m_ack[i] == 0) m_busy[i] = 0;
        end
      m_i2 = m_i1; m_i1 = m_irq;
      if (acc[0]) begin m_ctrl_b = wdata & 16'h0023; if (wdata[5]) m_lock = 1; end
      if (acc[1]) m_load_b = wdata;
      if (acc[2]) m_win_b = wdata;
      if (acc[3]) m_kok = (wdata == KEY);
      for (int i = 0; i < 4; i++) if (acc[i]) begin m_busy[i] = 1; m_sq[i] = 0; end
    end
  end

  always @(posedge clk_w) begin
    if (!rst_n) m_reset();
    else begin
      bit [3:0] ap;
      bit en, pds, act, kick, viol, good, run, ex;
      for (int i = 0; i < 4; i++) begin
        ap[i] = 0;
        if (m_sq[i] >= 0) begin
          m_sq[i]++;
          if (m_sq[i] == 3) begin ap[i] = 1; m_sq[i] = -1; m_ack[i] = 2; end
        end
      end
      en = m_ctrl_s[5]; pds = m_ctrl_s[1]; act = m_ctrl_s[0];
      kick = ap[3];
      viol = kick && (!m_kok || (en && m_cnt > m_win_s));
      good = kick && !viol;
      run = en && !(pds && lowpwr);
      ex = run && m_cnt == 0 && !kick;
      if (viol || ex) begin if (act) m_irq = 1; else m_rst = 1; end
      else if (good) m_irq = 0;
      if (!en || good || ex) m_cnt = m_load_s;
      else if (run) m_cnt = m_cnt - 1;
      if (ap[0]) m_ctrl_s = m_ctrl_b;
      if (ap[1]) m_load_s = m_load_b;
      if (ap[2]) m_win_s = m_win_b;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl_b;
      3'd1: return m_load_b;
      3'd2: return m_win_b;
      3'd4: return {10'd0, m_lock, m_busy, m_i2};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !stop) begin
      chk(wd_reset === m_rst, "R4 reset output vs model", 16'(wd_reset), 16'(m_rst));
      chk(wd_irq === m_irq, "R5 interrupt output vs model", 16'(wd_irq), 16'(m_irq));
      chk(rdata === exp_rd(addr),
          addr == 3'd4 ? "R7 status vs model" : (addr == 3'd3 ? "R3 refresh readback" : "R9 config readback"),
          rdata, exp_rd(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #3;
    chk(rdata === exp, tag, rdata, exp);
    addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; lowpwr = 0;
    idle(10);
    #3 rst_n = 1;
  endtask

  task automatic run_all();
    #103 rst_n = 1;
    // R12 reset values
    rd(3'd0, 16'h0002, "R12 control reset");
    rd(3'd1, LOAD0, "R12 reload reset");
    rd(3'd2, 16'hFFFF, "R12 window reset");
    rd(3'd4, 16'h0000, "R12 status reset");
    chk(!wd_reset && !wd_irq, "R12 outputs low", {wd_reset, wd_irq}, 0);

    // Phase A: interrupt mode
    wr(3'd3, KEY);
    #3 chk(rdata[4] === 1'b1, "R7 refresh busy set", rdata, 16'h0010);
    idle(40);
    chk(rdata[4] === 1'b0, "R7 refresh busy clear", rdata, 16'h0000);
    rd(3'd3, 16'h0000, "R3 refresh reads zero");
    wr(3'd1, 16'd20);
    wr(3'd1, 16'd99);
    idle(40);
    rd(3'd1, 16'd20, "R8 write while busy dropped");
    wr(3'd0, 16'h0003);
    idle(40);
    chk(rdata[5] === 1'b0, "R9 no lock without enable", rdata, 16'h0000);
    wr(3'd0, 16'h0023);
    idle(40);
    chk(rdata[5] === 1'b1, "R9 lock set", rdata, 16'h0020);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd5);
    idle(40);
    rd(3'd0, 16'h0023, "R9 control locked");
    rd(3'd1, 16'd20, "R9 reload locked");
    idle(300);
    chk(wd_irq === 1'b1, "R4 interrupt on expiry", 16'(wd_irq), 16'd1);
    chk(wd_reset === 1'b0, "R4 no reset in interrupt mode", 16'(wd_reset), 16'd0);
    #3 chk(rdata[0] === 1'b1, "R11 status interrupt bit", rdata, 16'h0001);
    wr(3'd3, KEY);
    idle(40);
    chk(wd_irq === 1'b0, "R1 valid key clears interrupt", 16'(wd_irq), 16'd0);
    lowpwr = 1;
    idle(400);
    chk(wd_irq === 1'b0, "R6 count frozen in low power", 16'(wd_irq), 16'd0);
    lowpwr = 0;
    idle(300);
    chk(wd_irq === 1'b1, "R6 count resumes after low power", 16'(wd_irq), 16'd1);
    wr(3'd3, KEY);
    idle(40);
    chk(wd_irq === 1'b0, "R1 interrupt cleared again", 16'(wd_irq), 16'd0);
    wr(3'd3, 16'h1234);
    idle(40);
    chk(wd_irq === 1'b1, "R2 wrong key violation", 16'(wd_irq), 16'd1);

    // Phase B: reset mode, early refresh
    do_reset();
    wr(3'd1, 16'd30);
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h0020);
    idle(40);
    wr(3'd3, KEY);
    idle(40);
    chk(wd_reset === 1'b1, "R10 early refresh is a violation", 16'(wd_reset), 16'd1);
    chk(wd_irq === 1'b0, "R4 no interrupt in reset mode", 16'(wd_irq), 16'd0);

    // Phase C: refresh inside window, then timeout during low power
    do_reset();
    lowpwr = 1;
    wr(3'd1, 16'd30);
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h0020);
    idle(176);
    wr(3'd3, KEY);
    idle(40);
    chk(wd_reset === 1'b0, "R10 refresh inside window accepted", 16'(wd_reset), 16'd0);
    idle(400);
    chk(wd_reset === 1'b1, "R6 counting continues in low power, R5 expiry", 16'(wd_reset), 16'd1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    stop = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule